// File: doc/BRIEF.md
# UART Receive/Transmit FIFO Controller

This block is the FIFO side of a UART. Software writes one 8-bit control register. That register picks the receive interrupt threshold, switches between FIFO mode and single-byte holding mode, and turns the transmit and receive paths on or off. The control register is write-only. A read at the same address returns an identification byte that describes the pending interrupt and the FIFO mode.

Two 16-entry byte FIFOs sit between the bus side and the serial shifters. Each shifter is modelled as a plain push or pop port. Setting the receive enable or the transmit enable to 0 does not just pulse a clear: the matching FIFO and its shift path stay in reset for as long as the bit remains 0. The receive interrupt line is driven straight from the receive occupancy and the selected threshold.

Top module: `uart_fifo_ctl`

## Requirements
- R1: After reset the control value is 0x00. Both FIFOs are empty, rxCount is 0, and rxIrq and rxOverrun are 0. identData reads 0x01.
- R2: With control bit 0 (FIFO mode) set, rxIrq is 1 exactly when rxCount is at least the threshold chosen by bits [7:6]. The codes are 00 for 1 byte, 01 for 4, 10 for 8 and 11 for 14.
- R3: With control bit 0 clear, rxIrq is 1 whenever rxCount is at least 1, whatever bits [7:6] hold.
- R4: rxIrq falls in the same cycle that a pop brings rxCount below the threshold.
- R5: Each FIFO holds 16 bytes and returns them in the order they were pushed. The head byte shows on the pop-data port. Full and empty flags report occupancy 16 and 0. A pop from an empty FIFO has no effect.
- R6: A receive push while the receive FIFO is full is dropped and sets rxOverrun. rxOverrun stays set through later pops. It is cleared only by a write that sets receive enable (bit 1) to 0.
- R7: A write that clears bit 1 empties the receive FIFO at that clock edge. rxPush has no effect while bit 1 is 0. After bit 1 is set again, the FIFO starts empty.
- R8: A write that clears bit 2 (transmit enable) empties the transmit FIFO at that clock edge. txPush and txPop have no effect while bit 2 is 0. After bit 2 is set again, the FIFO starts empty.
- R9: identData never shows the control value. Bits [7:6] are 11 in FIFO mode and 00 otherwise, bits [5:3] are 000, and bits [2:0] are 100 while rxIrq is 1 and 001 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctlWrEn | input | 1 | Write strobe for the control register |
| ctlWrData | input | 8 | Control write data |
| identData | output | 8 | Identification byte returned on a read at the shared address |
| txPush | input | 1 | Bus-side push into the transmit FIFO |
| txPushData | input | 8 | Byte to push into the transmit FIFO |
| txPop | input | 1 | Transmit shifter takes the head byte |
| txPopData | output | 8 | Head of the transmit FIFO |
| txFull | output | 1 | Transmit FIFO holds 16 bytes |
| txEmpty | output | 1 | Transmit FIFO is empty |
| rxPush | input | 1 | Receive shifter delivers a byte |
| rxPushData | input | 8 | Received byte |
| rxPop | input | 1 | Bus-side read of the head receive byte |
| rxPopData | output | 8 | Head of the receive FIFO |
| rxFull | output | 1 | Receive FIFO holds 16 bytes |
| rxEmpty | output | 1 | Receive FIFO is empty |
| rxCount | output | 5 | Receive FIFO occupancy |
| rxIrq | output | 1 | Receive data interrupt |
| rxOverrun | output | 1 | Sticky receive overrun flag |

## Verification
The bench sweeps every threshold code in both modes. For each one it fills the receive FIFO one byte at a time and drains it again, which targets the exact occupancy where the interrupt rises and falls. A design with an off-by-one threshold would raise or drop rxIrq one byte early or late. A design that keeps honouring bits [7:6] outside FIFO mode would hold the interrupt back until 4, 8 or 14 bytes had arrived. The 17th push finds a dropped byte or a lost sticky flag, and a FIFO that wraps would corrupt the drained order. The disable cases catch an enable that behaves as a one-shot clear: such a design would accept pushes while the enable is off, or resume with stale data after it is set again.

// File: rtl/uart_fifo_ctl_pkg.sv
package uart_fifo_ctl_pkg;

  typedef struct packed {
    logic       txClr;
    logic       rxClr;
    logic       txPushOk;
    logic       txPopOk;
    logic       rxPushOk;
    logic       rxPopOk;
    logic [1:0] trigSel;
    logic       fifoMode;
  } fifoStrobe_t;

  localparam int TX_EN_BIT = 2;
  localparam int RX_EN_BIT = 1;
  localparam int MODE_BIT  = 0;

  function automatic int unsigned trigBytes(input logic fifoMode, input logic [1:0] sel);
    if (!fifoMode) return 1;
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/ufc_fifo.sv
module ufc_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign doPush  = push && !full;
  assign doPop   = pop && !empty;
  assign popData = mem[rdPtr];

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr] <= pushData;
  end
endmodule

// File: rtl/ufc_ctl.sv
module ufc_ctl
  import uart_fifo_ctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctlWrEn,
  input  logic [7:0]  ctlWrData,
  input  logic        txPush,
  input  logic        txPop,
  input  logic        rxPush,
  input  logic        rxPop,
  output fifoStrobe_t strb
);
  logic [1:0] trigSel;
  logic txEn, rxEn, fifoMode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trigSel  <= '0;
      txEn     <= 1'b0;
      rxEn     <= 1'b0;
      fifoMode <= 1'b0;
    end else if (ctlWrEn) begin
      trigSel  <= ctlWrData[7:6];
      txEn     <= ctlWrData[TX_EN_BIT];
      rxEn     <= ctlWrData[RX_EN_BIT];
      fifoMode <= ctlWrData[MODE_BIT];
    end
  end

  always_comb begin
    strb.txClr    = !txEn || (ctlWrEn && !ctlWrData[TX_EN_BIT]);
    strb.rxClr    = !rxEn || (ctlWrEn && !ctlWrData[RX_EN_BIT]);
    strb.txPushOk = txPush && txEn;
    strb.txPopOk  = txPop && txEn;
    strb.rxPushOk = rxPush && rxEn;
    strb.rxPopOk  = rxPop && rxEn;
    strb.trigSel  = trigSel;
    strb.fifoMode = fifoMode;
  end
endmodule

// File: rtl/ufc_dp.sv
module ufc_dp
  import uart_fifo_ctl_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fifoStrobe_t      strb,
  input  logic [WIDTH-1:0] txPushData,
  input  logic [WIDTH-1:0] rxPushData,
  output logic [WIDTH-1:0] txPopData,
  output logic             txFull,
  output logic             txEmpty,
  output logic [WIDTH-1:0] rxPopData,
  output logic             rxFull,
  output logic             rxEmpty,
  output logic [CW-1:0]    rxCount,
  output logic             rxIrq,
  output logic             rxOverrun,
  output logic [7:0]       identData
);
  logic [CW-1:0] txCount;
  logic [CW-1:0] trigLvl;

  ufc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rst_n(rst_n), .clr(strb.txClr),
    .push(strb.txPushOk), .pushData(txPushData),
    .pop(strb.txPopOk), .popData(txPopData),
    .count(txCount), .full(txFull), .empty(txEmpty)
  );

  ufc_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rst_n(rst_n), .clr(strb.rxClr),
    .push(strb.rxPushOk), .pushData(rxPushData),
    .pop(strb.rxPopOk), .popData(rxPopData),
    .count(rxCount), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || strb.rxClr) rxOverrun <= 1'b0;
    else if (strb.rxPushOk && rxFull) rxOverrun <= 1'b1;
  end

  assign trigLvl   = CW'(trigBytes(strb.fifoMode, strb.trigSel));
  assign rxIrq     = (rxCount >= trigLvl);
  assign identData = {strb.fifoMode ? 2'b11 : 2'b00, 3'b000, rxIrq ? 3'b100 : 3'b001};
endmodule

// File: rtl/uart_fifo_ctl.sv
module uart_fifo_ctl
  import uart_fifo_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctlWrEn,
  input  logic [7:0] ctlWrData,
  output logic [7:0] identData,
  input  logic       txPush,
  input  logic [7:0] txPushData,
  input  logic       txPop,
  output logic [7:0] txPopData,
  output logic       txFull,
  output logic       txEmpty,
  input  logic       rxPush,
  input  logic [7:0] rxPushData,
  input  logic       rxPop,
  output logic [7:0] rxPopData,
  output logic       rxFull,
  output logic       rxEmpty,
  output logic [4:0] rxCount,
  output logic       rxIrq,
  output logic       rxOverrun
);
  localparam int DEPTH = 16;
  fifoStrobe_t strb;

  ufc_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .txPush(txPush), .txPop(txPop), .rxPush(rxPush), .rxPop(rxPop),
    .strb(strb)
  );

  ufc_dp #(.WIDTH(8), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .txPushData(txPushData), .rxPushData(rxPushData),
    .txPopData(txPopData), .txFull(txFull), .txEmpty(txEmpty),
    .rxPopData(rxPopData), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxCount(rxCount), .rxIrq(rxIrq), .rxOverrun(rxOverrun),
    .identData(identData)
  );
endmodule

// File: rtl/ufc_chk.sv
module ufc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctlWrEn,
  input logic [7:0] ctlWrData,
  input logic       rxPush,
  input logic       rxFull,
  input logic       rxEmpty,
  input logic [4:0] rxCount,
  input logic       rxIrq,
  input logic       rxOverrun,
  input logic       txFull,
  input logic       txEmpty,
  input logic [7:0] identData
);
  // R7
  rx_disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && !ctlWrData[1]) |=> (rxEmpty && !rxOverrun));

  // R8
  tx_disable_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctlWrEn && !ctlWrData[2]) |=> txEmpty);

  // R6
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxPush && rxFull && !ctlWrEn) |=> rxOverrun);

  // R2
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rxIrq |-> !rxEmpty);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxCount <= 5'd16) && !(txFull && txEmpty));

  // R9
  ident_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (identData[5:3] == 3'b000) && ((identData[7:6] == 2'b00) || (identData[7:6] == 2'b11)));
endmodule

bind uart_fifo_ctl ufc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
  .rxPush(rxPush), .rxFull(rxFull), .rxEmpty(rxEmpty), .rxCount(rxCount),
  .rxIrq(rxIrq), .rxOverrun(rxOverrun), .txFull(txFull), .txEmpty(txEmpty),
  .identData(identData)
);

// File: tb/test_uart_fifo_ctl.sv
`timescale 1ns/1ps
module test_uart_fifo_ctl;
  logic clk = 1'b0;
  logic rst_n;
  logic ctlWrEn = 1'b0;
  logic [7:0] ctlWrData = '0;
  logic [7:0] identData;
  logic txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [7:0] txPushData = '0, rxPushData = '0;
  logic [7:0] txPopData, rxPopData;
  logic txFull, txEmpty, rxFull, rxEmpty, rxIrq, rxOverrun;
  logic [4:0] rxCount;
  int nChecks = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  uart_fifo_ctl i_uart_fifo_ctl (
    .clk(clk), .rst_n(rst_n), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .identData(identData), .txPush(txPush), .txPushData(txPushData),
    .txPop(txPop), .txPopData(txPopData), .txFull(txFull), .txEmpty(txEmpty),
    .rxPush(rxPush), .rxPushData(rxPushData), .rxPop(rxPop),
    .rxPopData(rxPopData), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxCount(rxCount), .rxIrq(rxIrq), .rxOverrun(rxOverrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wrCtl(input logic [7:0] v);
    ctlWrEn = 1'b1; ctlWrData = v; tick; ctlWrEn = 1'b0;
  endtask

  task automatic rxIn(input logic [7:0] d);
    rxPush = 1'b1; rxPushData = d; tick; rxPush = 1'b0;
  endtask

  task automatic rxOut;
    rxPop = 1'b1; tick; rxPop = 1'b0;
  endtask

  task automatic txIn(input logic [7:0] d);
    txPush = 1'b1; txPushData = d; tick; txPush = 1'b0;
  endtask

  task automatic txOut;
    txPop = 1'b1; tick; txPop = 1'b0;
  endtask

  initial begin
    #(5.0 * 200000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tick; tick;
    rst_n = 1'b1;
    tick;
    // R1 reset state
    chk(rxCount == 0 && rxEmpty && txEmpty, "R1 empty", rxCount, 0);
    chk(!rxIrq && !rxOverrun, "R1 flags", {rxIrq, rxOverrun}, 0);
    chk(identData == 8'h01, "R1 ident", identData, 8'h01);

    // R7 / R8 pushes ignored while disabled
    rxIn(8'h11); txIn(8'h22);
    chk(rxEmpty && rxCount == 0, "R7 push ignored while off", rxCount, 0);
    chk(txEmpty, "R8 push ignored while off", txEmpty, 1);

    for (int fm = 0; fm < 2; fm++) begin
      for (int sel = 0; sel < 4; sel++) begin
        int lvl;
        logic [7:0] idleId, irqId;
        lvl = (fm == 0) ? 1 : (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
        idleId = (fm != 0) ? 8'hC1 : 8'h01;
        irqId  = (fm != 0) ? 8'hC4 : 8'h04;
        wrCtl({sel[1:0], 3'b000, 1'b0, 1'b1, fm[0]});
        chk(identData == idleId, "R9 ident idle", identData, idleId);
        for (int k = 1; k <= 16; k++) begin
          rxIn(8'(k * 7 + sel));
          chk(rxCount == 5'(k), "R5 count fill", rxCount, k);
          if (fm != 0) chk(rxIrq == (k >= lvl), "R2 threshold", rxIrq, k >= lvl);
          else         chk(rxIrq == 1'b1, "R3 single byte", rxIrq, 1);
          chk(rxFull == (k == 16), "R5 full flag", rxFull, k == 16);
          if (k == lvl) chk(identData == irqId, "R9 ident pending", identData, irqId);
        end
        rxIn(8'hEE);
        chk(rxOverrun == 1'b1, "R6 overrun set", rxOverrun, 1);
        chk(rxCount == 16, "R6 push dropped", rxCount, 16);
        for (int k = 1; k <= 16; k++) begin
          chk(rxPopData == 8'(k * 7 + sel), "R5 order", rxPopData, 8'(k * 7 + sel));
          rxOut;
          chk(rxIrq == ((16 - k) >= lvl), "R4 irq falls", rxIrq, (16 - k) >= lvl);
        end
        rxOut;
        chk(rxEmpty && rxCount == 0, "R5 pop on empty", rxCount, 0);
        chk(rxOverrun == 1'b1, "R6 sticky", rxOverrun, 1);
        wrCtl({sel[1:0], 3'b000, 1'b0, 1'b0, fm[0]});
        chk(rxOverrun == 1'b0, "R6 cleared by disable", rxOverrun, 0);
      end
    end

    // R7 disable mid-fill, re-enable starts empty
    wrCtl(8'h03);
    rxIn(8'h31); rxIn(8'h32); rxIn(8'h33);
    wrCtl(8'h01);
    chk(rxCount == 0 && !rxIrq, "R7 disable empties", rxCount, 0);
    rxIn(8'h44);
    chk(rxCount == 0, "R7 ignored while off", rxCount, 0);
    wrCtl(8'h03);
    chk(rxEmpty, "R7 restart empty", rxCount, 0);
    rxIn(8'h5A);
    chk(rxPopData == 8'h5A && rxCount == 1, "R7 fresh head", rxPopData, 8'h5A);

    // R8 transmit path
    wrCtl(8'h07);
    for (int k = 0; k < 16; k++) txIn(8'(8'h40 + k));
    chk(txFull, "R5 tx full", txFull, 1);
    txIn(8'hFF);
    for (int k = 0; k < 3; k++) begin
      chk(txPopData == 8'(8'h40 + k), "R5 tx order", txPopData, 8'(8'h40 + k));
      txOut;
    end
    chk(!txFull && !txEmpty, "R5 tx partial", txFull, 0);
    wrCtl(8'h03);
    chk(txEmpty, "R8 disable empties", txEmpty, 1);
    txIn(8'h77); txOut;
    chk(txEmpty, "R8 ignored while off", txEmpty, 1);
    wrCtl(8'h07);
    chk(txEmpty, "R8 restart empty", txEmpty, 1);
    txIn(8'h99);
    chk(txPopData == 8'h99 && !txEmpty, "R8 fresh head", txPopData, 8'h99);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule